// File: doc/BRIEF.md
# Debug Cycle Counter

This block is a debug event counter for an on-chip debug unit. A 16-bit control word sets three things. The first is which bus activity advances the count: reaction pulses, instruction fetches, CPU bus cycles, DMA bus cycles, or any bus cycle. The other two are which events arm and halt counting. A third source field picks an event that zeroes the count. The source events are a reaction pulse, the CPU entering or leaving debug halt, and a start pulse from a companion counter. The counter drives its own start pulse so that two instances can be chained.

The count is `2*WORD_W` bits wide, which is 32 by default. Software reads it as two words. The low word is always live. Reading the low word copies the high half into a shadow, so the pair that is read belongs to the same instant.

The run control is a two-state machine. HOLD is the state after reset and after any control write. COUNT is the only state in which increments are taken. There are three transitions. Arm moves HOLD to COUNT when the selected start event is present. Halt moves COUNT to HOLD when the selected stop event is present. A control write forces either state to HOLD.

Top module: `dbg_cyc_counter`

## Requirements
- R1: After reset the count is zero, the latched high word is zero, the machine is in HOLD (`running` low), `start_pulse` is low, and the control word is all zeros.
- R2: Bits [2:0] of the control word pick the increment source. Code 0 counts nothing. Code 1 counts `ev_react`. Code 4 counts `ev_fetch`. Code 5 counts cycles with `ev_cpu_bus` or `ev_dma_bus` high. Code 6 counts `ev_cpu_bus` cycles only when `ev_dma_bus` is low. Code 7 counts `ev_dma_bus` cycles. Codes 2 and 3 count nothing. An increment is taken only in COUNT, at most one per cycle.
- R3: Bits [9:8] pick the arm event. 00 is the falling edge of `cpu_halted`. 01 is `ev_react`. 10 is `peer_start`. 11 means always. In HOLD, when that event is present, the machine enters COUNT on the next edge, and `start_pulse` is high for exactly that one cycle.
- R4: Bits [11:10] pick the halt event. 00 is the rising edge of `cpu_halted`. 01 is `ev_react`. 10 is `peer_start`. 11 means never. In COUNT, when that event is present, the machine returns to HOLD on the next edge, and the count is kept.
- R5: Bits [13:12] pick the zeroing event. 01 is `ev_react` and 10 is `peer_start`. Codes 00 and 11 zero nothing.
- R6: When a zeroing event and an increment fall in the same cycle, the count becomes zero.
- R7: A control write forces HOLD, and no increment or source event acts in that cycle. Bit 6 of the written word zeroes the count and is not stored. A write with bit 6 clear leaves the count unchanged.
- R8: `word_lo` is the live low half of the count. A cycle with `lo_rd` high copies the high half into `word_hi`, which holds that value until the next such cycle.
- R9: The count wraps from all ones to zero.
- R10: The edges of `cpu_halted` are taken against its value in the previous cycle. 0 to 1 is the halt edge and 1 to 0 is the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word value |
| ev_react | input | 1 | Reaction pulse |
| ev_fetch | input | 1 | Instruction fetch cycle |
| ev_cpu_bus | input | 1 | CPU bus cycle |
| ev_dma_bus | input | 1 | DMA bus cycle |
| cpu_halted | input | 1 | CPU in debug halt (level) |
| peer_start | input | 1 | Companion counter start pulse |
| lo_rd | input | 1 | Low-word read strobe, latches the high half |
| word_lo | output | WORD_W | Live low half of the count |
| word_hi | output | WORD_W | High half latched at the last low read |
| running | output | 1 | Machine is in COUNT |
| start_pulse | output | 1 | One-cycle pulse on entry to COUNT |

## Verification
Each counting mode is driven with fetch, CPU and DMA activity, alone and overlapping. Only the selected mode's own filter gives the expected total, so a wrong mode decode or a wrong CPU/DMA exclusion shows up as a different count. Arm and halt are exercised through every source: the halt-level edges, reaction pulses, companion pulses and the unconditional codes. Between these, activity is driven while the machine is in HOLD, which separates a gated count from a free-running one. The zeroing sources are tried alone, together with an increment, and under the reserved code. A narrow instance takes the count past the low half and through wrap, which shows that the high word changes only on a low read.

// File: rtl/dbg_cyc_pkg.sv
package dbg_cyc_pkg;

    localparam int CTL_W    = 16;
    localparam int N_SRC_FL = 3;   // arm, halt, zero source fields

    typedef enum logic [2:0] {
        MODE_OFF    = 3'd0,
        MODE_REACT  = 3'd1,
        MODE_RSV2   = 3'd2,
        MODE_RSV3   = 3'd3,
        MODE_FETCH  = 3'd4,
        MODE_ALLBUS = 3'd5,
        MODE_CPU    = 3'd6,
        MODE_DMA    = 3'd7
    } inc_mode_e;

    // Meaning of codes 0 and 3 depends on the field using them.
    typedef enum logic [1:0] {
        SRC_CODE0 = 2'b00,
        SRC_REACT = 2'b01,
        SRC_PEER  = 2'b10,
        SRC_CODE3 = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic [1:0] spare_hi;   // 15:14
        src_sel_e   zero_src;   // 13:12
        src_sel_e   halt_src;   // 11:10
        src_sel_e   arm_src;    // 9:8
        logic       spare_b7;   // 7
        logic       zero_req;   // 6
        logic [2:0] spare_mid;  // 5:3
        inc_mode_e  mode;       // 2:0
    } ctl_word_t;

    typedef enum logic {
        ST_HOLD  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/dbg_cyc_evsel.sv
module dbg_cyc_evsel
    import dbg_cyc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_sel_e arm_src,
    input  src_sel_e halt_src,
    input  src_sel_e zero_src,
    input  logic     ev_react,
    input  logic     cpu_halted,
    input  logic     peer_start,
    output logic     arm_hit,
    output logic     halt_hit,
    output logic     zero_hit
);

    logic halted_q;
    logic halt_edge;
    logic release_edge;

    always_ff @(posedge clk) begin
        if (!rst_n) halted_q <= 1'b0;
        else        halted_q <= cpu_halted;
    end

    assign halt_edge    =  cpu_halted & ~halted_q;
    assign release_edge = ~cpu_halted &  halted_q;

    // Field index: 0 arm, 1 halt, 2 zero.
    src_sel_e              sel [N_SRC_FL];
    logic [N_SRC_FL-1:0]   code0_ev;
    logic [N_SRC_FL-1:0]   code3_ev;
    logic [N_SRC_FL-1:0]   hit;

    assign sel[0] = arm_src;
    assign sel[1] = halt_src;
    assign sel[2] = zero_src;

    // Code 0: arm on release, halt on halt edge, zero never.
    assign code0_ev = {1'b0, halt_edge, release_edge};
    // Code 3: arm always, halt never, zero never (reserved).
    assign code3_ev = {1'b0, 1'b0, 1'b1};

    function automatic logic pick_src(
        input src_sel_e s,
        input logic     c0,
        input logic     c3,
        input logic     re,
        input logic     pe
    );
        logic r;
        unique case (s)
            SRC_CODE0: r = c0;
            SRC_REACT: r = re;
            SRC_PEER:  r = pe;
            SRC_CODE3: r = c3;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

    generate
        for (genvar f = 0; f < N_SRC_FL; f++) begin : g_field
            assign hit[f] = pick_src(sel[f], code0_ev[f], code3_ev[f],
                                     ev_react, peer_start);
        end
    endgenerate

    assign arm_hit  = hit[0];
    assign halt_hit = hit[1];
    assign zero_hit = hit[2];

endmodule

// File: rtl/dbg_cyc_incsel.sv
module dbg_cyc_incsel
    import dbg_cyc_pkg::*;
(
    input  inc_mode_e mode,
    input  logic      ev_react,
    input  logic      ev_fetch,
    input  logic      ev_cpu_bus,
    input  logic      ev_dma_bus,
    output logic      inc_hit
);

    always_comb begin
        unique case (mode)
            MODE_REACT:  inc_hit = ev_react;
            MODE_FETCH:  inc_hit = ev_fetch;
            MODE_ALLBUS: inc_hit = ev_cpu_bus | ev_dma_bus;
            MODE_CPU:    inc_hit = ev_cpu_bus & ~ev_dma_bus;
            MODE_DMA:    inc_hit = ev_dma_bus;
            MODE_OFF,
            MODE_RSV2,
            MODE_RSV3:   inc_hit = 1'b0;
            default:     inc_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/dbg_cyc_fsm.sv
module dbg_cyc_fsm
    import dbg_cyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic arm_hit,
    input  logic halt_hit,
    output logic running,
    output logic start_pulse
);

    run_state_e state_q;
    run_state_e state_d;
    logic       pulse_q;
    logic       pulse_d;

    // Next state and the entry pulse.
    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        if (ctl_wr) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: begin
                    if (arm_hit) begin
                        state_d = ST_COUNT;
                        pulse_d = 1'b1;
                    end
                end
                ST_COUNT: begin
                    if (halt_hit) state_d = ST_HOLD;
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            pulse_q <= 1'b0;
        end else begin
            state_q <= state_d;
            pulse_q <= pulse_d;
        end
    end

    assign running     = (state_q == ST_COUNT);
    assign start_pulse = pulse_q;

endmodule

// File: rtl/dbg_cyc_acc.sv
module dbg_cyc_acc #(
    parameter  int WORD_W = 16,
    localparam int CNT_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              zero_now,
    input  logic              bump,
    input  logic              lo_rd,
    output logic [WORD_W-1:0] word_lo,
    output logic [WORD_W-1:0] word_hi
);

    logic [CNT_W-1:0]  count_q;
    logic [WORD_W-1:0] hi_shadow_q;

    always_ff @(posedge clk) begin
        if (!rst_n)        count_q <= '0;
        else if (zero_now) count_q <= '0;
        else if (bump)     count_q <= count_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     hi_shadow_q <= '0;
        else if (lo_rd) hi_shadow_q <= count_q[CNT_W-1:WORD_W];
    end

    assign word_lo = count_q[WORD_W-1:0];
    assign word_hi = hi_shadow_q;

endmodule

// File: rtl/dbg_cyc_counter.sv
module dbg_cyc_counter
    import dbg_cyc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ev_react,
    input  logic              ev_fetch,
    input  logic              ev_cpu_bus,
    input  logic              ev_dma_bus,
    input  logic              cpu_halted,
    input  logic              peer_start,
    input  logic              lo_rd,
    output logic [WORD_W-1:0] word_lo,
    output logic [WORD_W-1:0] word_hi,
    output logic              running,
    output logic              start_pulse
);

    ctl_word_t ctl_in;
    inc_mode_e mode_q;
    src_sel_e  arm_q;
    src_sel_e  halt_q;
    src_sel_e  zsrc_q;

    logic arm_hit;
    logic stop_hit;
    logic clear_hit;
    logic inc_hit;
    logic zero_now;
    logic bump;
    logic unused_spare;

    assign ctl_in       = ctl_word_t'(ctl_wdata);
    assign unused_spare = ^{ctl_in.spare_hi, ctl_in.spare_b7, ctl_in.spare_mid};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            arm_q  <= SRC_CODE0;
            halt_q <= SRC_CODE0;
            zsrc_q <= SRC_CODE0;
        end else if (ctl_wr) begin
            mode_q <= ctl_in.mode;
            arm_q  <= ctl_in.arm_src;
            halt_q <= ctl_in.halt_src;
            zsrc_q <= ctl_in.zero_src;
        end
    end

    dbg_cyc_evsel u_evsel (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_src    (arm_q),
        .halt_src   (halt_q),
        .zero_src   (zsrc_q),
        .ev_react   (ev_react),
        .cpu_halted (cpu_halted),
        .peer_start (peer_start),
        .arm_hit    (arm_hit),
        .halt_hit   (stop_hit),
        .zero_hit   (clear_hit)
    );

    dbg_cyc_incsel u_incsel (
        .mode       (mode_q),
        .ev_react   (ev_react),
        .ev_fetch   (ev_fetch),
        .ev_cpu_bus (ev_cpu_bus),
        .ev_dma_bus (ev_dma_bus),
        .inc_hit    (inc_hit)
    );

    dbg_cyc_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_wr      (ctl_wr),
        .arm_hit     (arm_hit),
        .halt_hit    (stop_hit),
        .running     (running),
        .start_pulse (start_pulse)
    );

    // A write owns its cycle: only its zero request may touch the count.
    assign zero_now = ctl_wr ? ctl_in.zero_req : clear_hit;
    assign bump     = running & inc_hit & ~ctl_wr;

    dbg_cyc_acc #(.WORD_W(WORD_W)) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .zero_now (zero_now),
        .bump     (bump),
        .lo_rd    (lo_rd),
        .word_lo  (word_lo),
        .word_hi  (word_hi)
    );

endmodule

// File: rtl/dbg_cyc_counter_chk.sv
module dbg_cyc_counter_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_wr,
    input logic              lo_rd,
    input logic              running,
    input logic              start_pulse,
    input logic              stop_hit,
    input logic              zero_now,
    input logic [WORD_W-1:0] word_lo,
    input logic [WORD_W-1:0] word_hi
);

    // R3
    pulse_on_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (running && !$past(running)));

    // R7
    write_forces_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr |=> (!running && !start_pulse));

    // R4
    halt_leaves_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && stop_hit && !ctl_wr) |=> !running);

    // R6
    zero_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_now |=> (word_lo == '0));

    // R2
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !zero_now |=> ((word_lo == $past(word_lo)) || (word_lo == $past(word_lo) + 1'b1)));

    // R8
    hi_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lo_rd |=> $stable(word_hi));

endmodule

bind dbg_cyc_counter dbg_cyc_counter_chk #(.WORD_W(WORD_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_wr      (ctl_wr),
    .lo_rd       (lo_rd),
    .running     (running),
    .start_pulse (start_pulse),
    .stop_hit    (stop_hit),
    .zero_now    (zero_now),
    .word_lo     (word_lo),
    .word_hi     (word_hi)
);

// File: tb/dbg_cyc_counter_bench.sv
`timescale 1ns/1ps
module dbg_cyc_counter_bench;

    localparam int W  = 16;
    localparam int NW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr = 1'b0;
    logic [15:0]   ctl_wdata = '0;
    logic          ev_react = 1'b0, ev_fetch = 1'b0, ev_cpu_bus = 1'b0, ev_dma_bus = 1'b0;
    logic          cpu_halted = 1'b0, peer_start = 1'b0, lo_rd = 1'b0;
    logic [W-1:0]  word_lo, word_hi;
    logic          running, start_pulse;
    logic [NW-1:0] n_lo, n_hi;
    logic          n_running, n_pulse;

    always #4 clk = ~clk;   // 125 MHz

    dbg_cyc_counter #(.WORD_W(W)) u_dbg_cyc_counter (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ev_react(ev_react), .ev_fetch(ev_fetch), .ev_cpu_bus(ev_cpu_bus),
        .ev_dma_bus(ev_dma_bus), .cpu_halted(cpu_halted), .peer_start(peer_start),
        .lo_rd(lo_rd), .word_lo(word_lo), .word_hi(word_hi),
        .running(running), .start_pulse(start_pulse)
    );

    dbg_cyc_counter #(.WORD_W(NW)) u_dbg_cyc_counter_narrow (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .ev_react(ev_react), .ev_fetch(ev_fetch), .ev_cpu_bus(ev_cpu_bus),
        .ev_dma_bus(ev_dma_bus), .cpu_halted(cpu_halted), .peer_start(peer_start),
        .lo_rd(lo_rd), .word_lo(n_lo), .word_hi(n_hi),
        .running(n_running), .start_pulse(n_pulse)
    );

    typedef struct {
        int          due;
        int          sel;   // 0 lo, 1 hi, 2 running, 3 pulse, 4 narrow lo, 5 narrow hi
        logic [31:0] exp;
        string       tag;
    } exp_item_t;

    exp_item_t sb_q[$];
    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic logic [31:0] observe(input int sel);
        case (sel)
            0:       return 32'(word_lo);
            1:       return 32'(word_hi);
            2:       return 32'(running);
            3:       return 32'(start_pulse);
            4:       return 32'(n_lo);
            default: return 32'(n_hi);
        endcase
    endfunction

    // Monitor: samples 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        cyc = cyc + 1;
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            exp_item_t it;
            logic [31:0] act;
            it = sb_q.pop_front();
            act = observe(it.sel);
            checks = checks + 1;
            if (it.due != cyc || act !== it.exp) begin
                errors = errors + 1;
                $display("FAIL %s sel=%0d cyc=%0d actual=%0d expected=%0d",
                         it.tag, it.sel, cyc, act, it.exp);
            end
        end
    end

    task automatic expect_at(input int d, input int sel, input logic [31:0] v, input string tag);
        exp_item_t it;
        it.due = cyc + d; it.sel = sel; it.exp = v; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
    endtask

    task automatic drive(input logic f, input logic c, input logic d,
                         input logic r, input logic p, input int n);
        repeat (n) begin
            @(negedge clk);
            ev_fetch = f; ev_cpu_bus = c; ev_dma_bus = d; ev_react = r; peer_start = p;
        end
        @(negedge clk);
        ev_fetch = 0; ev_cpu_bus = 0; ev_dma_bus = 0; ev_react = 0; peer_start = 0;
    endtask

    task automatic read_lo();
        @(negedge clk); lo_rd = 1'b1;
        @(negedge clk); lo_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_at(1, 0, 0, "R1 lo"); expect_at(1, 1, 0, "R1 hi");
        expect_at(1, 2, 0, "R1 running"); expect_at(1, 3, 0, "R1 pulse");
        @(negedge clk);

        // R2 fetch mode, arm always, never halt; R3 entry pulse
        wr_ctl(16'h0F04);
        expect_at(1, 3, 1, "R3 pulse high"); expect_at(1, 2, 1, "R3 running");
        expect_at(2, 3, 0, "R3 pulse one cycle");
        drive(1, 1, 0, 0, 0, 5);
        drive(0, 0, 1, 0, 0, 3);
        expect_at(1, 0, 5, "R2 fetch mode");

        // R2 CPU-only mode, R7 zero bit
        wr_ctl(16'h0F46);
        expect_at(1, 0, 0, "R7 zero bit");
        drive(0, 1, 0, 0, 0, 4); drive(0, 0, 1, 0, 0, 2); drive(0, 1, 1, 0, 0, 3);
        expect_at(1, 0, 4, "R2 cpu mode excludes dma");

        // R2 DMA mode
        wr_ctl(16'h0F47);
        drive(0, 0, 1, 0, 0, 2); drive(0, 1, 1, 0, 0, 3); drive(0, 1, 0, 0, 0, 4);
        expect_at(1, 0, 5, "R2 dma mode");

        // R2 all-bus mode
        wr_ctl(16'h0F45);
        drive(0, 1, 0, 0, 0, 2); drive(0, 0, 1, 0, 0, 3); drive(0, 1, 1, 0, 0, 1);
        expect_at(1, 0, 6, "R2 all-bus mode");

        // R2 reaction mode
        wr_ctl(16'h0F41);
        drive(0, 0, 0, 1, 0, 3); drive(1, 1, 1, 0, 0, 2);
        expect_at(1, 0, 3, "R2 reaction mode");

        // R2 off mode
        wr_ctl(16'h0F40);
        drive(1, 1, 1, 1, 0, 4);
        expect_at(1, 0, 0, "R2 off mode"); expect_at(1, 2, 1, "R2 running while off");

        // R7 write without zero bit keeps count and forces HOLD
        wr_ctl(16'h0F44);
        drive(1, 0, 0, 0, 0, 3);
        wr_ctl(16'h0C04);
        expect_at(1, 0, 3, "R7 count kept"); expect_at(1, 2, 0, "R7 hold after write");
        drive(1, 0, 0, 0, 0, 3);
        expect_at(1, 0, 3, "R3 no count before arm");

        // R10/R3 arm on release edge
        @(negedge clk); cpu_halted = 1'b1;
        @(negedge clk);
        expect_at(1, 2, 0, "R10 halt rise does not arm");
        @(negedge clk); cpu_halted = 1'b0;
        expect_at(1, 3, 1, "R10 release arms"); expect_at(2, 3, 0, "R3 pulse ends");
        drive(1, 0, 0, 0, 0, 4);
        expect_at(1, 0, 7, "R3 counting after release");

        // R4/R10 halt edge stops; arm on reaction
        wr_ctl(16'h0104);
        drive(0, 0, 0, 1, 0, 1);
        expect_at(1, 2, 1, "R3 reaction arms");
        drive(1, 0, 0, 0, 0, 2);
        @(negedge clk); cpu_halted = 1'b1;
        expect_at(1, 2, 0, "R4 halt edge stops");
        drive(1, 0, 0, 0, 0, 3);
        expect_at(1, 0, 9, "R4 count kept after stop");
        @(negedge clk); cpu_halted = 1'b0;
        expect_at(2, 2, 0, "R3 release ignored when arm is reaction");
        @(negedge clk);

        // R4 stop on peer; R5 code 00 does not zero
        wr_ctl(16'h0944);
        drive(0, 0, 0, 1, 0, 1);
        drive(1, 0, 0, 0, 0, 2);
        drive(0, 0, 0, 0, 1, 1);
        expect_at(1, 2, 0, "R4 peer stops");
        drive(1, 0, 0, 0, 0, 2);
        expect_at(1, 0, 2, "R5 none keeps count");

        // R3 arm on peer, R4 stop on reaction
        wr_ctl(16'h0644);
        drive(0, 0, 0, 0, 1, 1);
        expect_at(1, 2, 1, "R3 peer arms");
        drive(1, 0, 0, 0, 0, 3);
        drive(0, 0, 0, 1, 0, 1);
        expect_at(1, 2, 0, "R4 reaction stops"); expect_at(1, 0, 3, "R4 count at stop");

        // R5 zero on reaction, R6 zero beats increment
        wr_ctl(16'h1F44);
        drive(1, 0, 0, 0, 0, 5);
        expect_at(1, 0, 5, "R5 pre-zero");
        drive(0, 0, 0, 1, 0, 1);
        expect_at(1, 0, 0, "R5 reaction zeroes");
        drive(1, 0, 0, 0, 0, 2);
        drive(1, 0, 0, 1, 0, 1);
        expect_at(1, 0, 0, "R6 zero wins");

        // R5 zero on peer
        wr_ctl(16'h2F04);
        drive(1, 0, 0, 0, 0, 3);
        drive(0, 0, 0, 0, 1, 1);
        expect_at(1, 0, 0, "R5 peer zeroes");

        // R5 reserved code zeroes nothing
        wr_ctl(16'h3F04);
        drive(1, 0, 0, 0, 0, 3);
        drive(0, 0, 0, 1, 0, 1);
        drive(0, 0, 0, 0, 1, 1);
        expect_at(1, 0, 3, "R5 reserved code");

        // R8/R9 read coherence and wrap on the narrow instance
        wr_ctl(16'h0F44);
        drive(1, 0, 0, 0, 0, 6);
        read_lo();
        expect_at(1, 4, 2, "R8 narrow lo"); expect_at(1, 5, 1, "R8 narrow hi latched");
        expect_at(1, 0, 6, "R8 main lo"); expect_at(1, 1, 0, "R8 main hi");
        drive(1, 0, 0, 0, 0, 3);
        expect_at(1, 4, 1, "R8 narrow lo live"); expect_at(1, 5, 1, "R8 hi holds without read");
        read_lo();
        expect_at(1, 5, 2, "R8 hi after second read");
        drive(1, 0, 0, 0, 0, 7);
        expect_at(1, 4, 0, "R9 narrow wraps lo"); expect_at(1, 0, 16, "R9 main lo");
        read_lo();
        expect_at(1, 5, 0, "R9 narrow wraps hi");

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) begin
            errors = errors + 1;
            $display("FAIL scoreboard left=%0d actual=%0d expected=0", sb_q.size(), sb_q.size());
        end
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule